// File: doc/BRIEF.md
# Ten-Bit-Addressed I2C Slave Transmitter

This block is an I2C slave that answers a master read sent to a 10-bit address. It watches the open-drain SCL and SDA lines through input samples and pulls either line low through an enable output. A host next to it sees an address register, a transmit buffer, and four status or control bits: buffer full, interrupt, address-update-needed and clock release. The block stretches SCL whenever it needs the host to act.

A transaction has three header bytes. The first is the write header: `11110`, then address bits A9:A8, then R/W=0. After it is acknowledged, SCL is held low until the host loads the low address byte into the address register. The second byte must equal that low byte. After it is acknowledged, SCL is held low again until the host writes the high header byte back into the register. After a repeated start, the master sends the read header, which is the first byte again but with R/W=1. The slave acknowledges it, clears the clock-release bit and holds SCL low. It releases SCL only once the host has written a data byte and set the clock-release bit. The byte is then shifted out MSB first. If the master acknowledges it, the slave stretches again for the next byte. If the master does not acknowledge, the slave lets go of both lines and waits for a stop or a repeated start.

States and transitions:
- `ST_IDLE`:
  - goes to `ST_HDR_W` on a start.
  - goes to `ST_HDR_R` on a start while the block is addressed.
- `ST_HDR_W`: on a header match, goes to `ST_ACK_W`, which goes to `ST_HOLD_LO` at the end of the ninth clock.
- `ST_HOLD_LO`: on an address write, goes to `ST_RX_LO`.
- `ST_RX_LO`: on a low-byte match, goes to `ST_ACK_LO`, which then goes to `ST_HOLD_HI`.
- `ST_HOLD_HI`: on an address write, goes to `ST_WAIT_SR`, which goes to `ST_HDR_R` on a repeated start.
- `ST_HDR_R`: on a match, goes to `ST_ACK_R`, which goes to `ST_HOLD_TX`.
- `ST_HOLD_TX`: goes to `ST_TX_BIT` once a byte is pending and release is set.
- `ST_TX_BIT`: goes to `ST_TX_ACK` after eight bits.
- `ST_TX_ACK`:
  - returns to `ST_HOLD_TX` on a master ACK.
  - goes to `ST_NACK_WAIT` on a NACK.
- Any mismatch goes to `ST_IDLE`.
- A stop in any state goes to `ST_IDLE`.

Top module: `i2c10_slave_tx`

## Requirements
- R1: After reset, `scl_oe`, `sda_oe`, `buf_full`, `irq_flag` and `upd_addr` are 0, and `clk_rel` is 1.
- R2: After a start, an eight-bit byte equal to `11110`, then address register bits [2:1], then a 0 LSB is acknowledged by pulling SDA low for the ninth clock. Any other byte is not acknowledged, and later bytes are ignored until the next start.
- R3: After each acknowledged write-phase address byte, `upd_addr` becomes 1 and SCL is held low. A host address write clears `upd_addr` and releases SCL in the same clock.
- R4: The second address byte is acknowledged only if all eight bits equal the address register. The register holds the low byte written by the host during the first hold.
- R5: `buf_full` is set when an address byte is acknowledged. A `buf_rd` strobe clears it.
- R6: `irq_flag` is set at the end of the ninth clock of every acknowledged address byte and of every transmitted data byte. It stays set until `flag_clr`.
- R7: After a repeated start that follows a completed address exchange, the header with LSB 1 is acknowledged and `clk_rel` is cleared. SCL stays low until a byte is written to the transmit buffer and `rel_set` has been pulsed.
- R8: A transmit write sets `buf_full`. The byte goes out MSB first on eight clocks, and `buf_full` clears once the eighth bit has been clocked.
- R9: A master ACK on the ninth clock clears `clk_rel` and holds SCL low again. A NACK leaves both lines released with no stretching.
- R10: A stop returns the block to idle with both lines released. A read header that follows a new start without a new address exchange is not acknowledged.
- R11: `sda_oe` changes only while the SCL line is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_i | input | 1 | Sampled SCL line level |
| sda_i | input | 1 | Sampled SDA line level |
| scl_oe | output | 1 | Pull SCL low (clock stretch) |
| sda_oe | output | 1 | Pull SDA low |
| addr_wr | input | 1 | Host write strobe for the address register |
| addr_wdata | input | 8 | Address register write data |
| tx_wr | input | 1 | Host write strobe for the transmit buffer |
| tx_wdata | input | 8 | Transmit byte |
| buf_rd | input | 1 | Host buffer read strobe (clears buffer full) |
| rel_set | input | 1 | Sets the clock-release bit |
| flag_clr | input | 1 | Clears the interrupt flag |
| buf_full | output | 1 | Buffer full flag |
| irq_flag | output | 1 | Byte-complete interrupt flag |
| upd_addr | output | 1 | Address register must be rewritten |
| clk_rel | output | 1 | Clock-release bit |

## Verification
The assertions check several rules on every cycle:
- SDA only switches while SCL is low.
- A pending address update always comes with a held clock, and an address write clears that update flag.
- A buffer read during a stretch empties the buffer.
- The interrupt flag and the cleared release bit stay put until the host acts.

Only the bench scenarios can show the rest: which header and low bytes get acknowledged, the order of the transmitted bits, how the flags behave on a master ACK versus a NACK, and that a stop forgets the addressed state. Randomised addresses, corrupted bytes and data patterns drive all of these.

// File: rtl/i2c10_pkg.sv
package i2c10_pkg;
    localparam int BYTE_W = 8;
    localparam logic [4:0] HDR_MARK = 5'b11110;

    typedef enum logic [3:0] {
        ST_IDLE, ST_HDR_W, ST_ACK_W, ST_HOLD_LO, ST_RX_LO, ST_ACK_LO,
        ST_HOLD_HI, ST_WAIT_SR, ST_HDR_R, ST_ACK_R, ST_HOLD_TX,
        ST_TX_BIT, ST_TX_ACK, ST_NACK_WAIT
    } slv_state_e;

    function automatic logic hdr_hit(input logic [BYTE_W-1:0] rx,
                                     input logic [BYTE_W-1:0] areg,
                                     input logic rw);
        return (rx[7:3] == HDR_MARK) && (rx[2:1] == areg[2:1]) && (rx[0] == rw);
    endfunction
endpackage

// File: rtl/i2c10_line_mon.sv
module i2c10_line_mon #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic sda_now,
    output logic scl_rise,
    output logic scl_fall,
    output logic bus_start,
    output logic bus_stop
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] scl_ff, sda_ff;
    logic scl_old, sda_old, scl_now;

    // synchroniser chain, one flop per stage
    for (genvar g = 0; g < SYNC_STAGES; g++) begin : g_sync
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                scl_ff[g] <= 1'b1;
                sda_ff[g] <= 1'b1;
            end else begin
                scl_ff[g] <= (g == 0) ? scl_i : scl_ff[(g == 0) ? 0 : g-1];
                sda_ff[g] <= (g == 0) ? sda_i : sda_ff[(g == 0) ? 0 : g-1];
            end
        end
    end

    assign scl_now = scl_ff[TOP];
    assign sda_now = sda_ff[TOP];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            scl_old <= 1'b1;
            sda_old <= 1'b1;
        end else begin
            scl_old <= scl_now;
            sda_old <= sda_now;
        end
    end

    assign scl_rise  = scl_now & ~scl_old;
    assign scl_fall  = ~scl_now & scl_old;
    assign bus_start = scl_now & scl_old & sda_old & ~sda_now;
    assign bus_stop  = scl_now & scl_old & ~sda_old & sda_now;
endmodule

// File: rtl/i2c10_bit_engine.sv
module i2c10_bit_engine #(
    parameter int W    = 8,
    parameter int CNT_W = $clog2(W + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             load,
    input  logic [W-1:0]     load_val,
    input  logic             shift_en,
    input  logic             shift_in,
    output logic [W-1:0]     data,
    output logic [CNT_W-1:0] cnt
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data <= '0;
            cnt  <= '0;
        end else if (clr) begin
            cnt  <= '0;
        end else if (load) begin
            data <= load_val;
            cnt  <= '0;
        end else if (shift_en) begin
            data <= {data[W-2:0], shift_in};
            cnt  <= cnt + 1'b1;
        end
    end
endmodule

// File: rtl/i2c10_slave_tx.sv
module i2c10_slave_tx
    import i2c10_pkg::*;
#(
    parameter int               SYNC_STAGES = 2,
    parameter logic [BYTE_W-1:0] ADDR_RESET = 8'hF2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              scl_oe,
    output logic              sda_oe,
    input  logic              addr_wr,
    input  logic [BYTE_W-1:0] addr_wdata,
    input  logic              tx_wr,
    input  logic [BYTE_W-1:0] tx_wdata,
    input  logic              buf_rd,
    input  logic              rel_set,
    input  logic              flag_clr,
    output logic              buf_full,
    output logic              irq_flag,
    output logic              upd_addr,
    output logic              clk_rel
);
    localparam int CNT_W = $clog2(BYTE_W + 1);
    localparam logic [CNT_W-1:0] LAST_RX = CNT_W'(BYTE_W);
    localparam logic [CNT_W-1:0] LAST_TX = CNT_W'(BYTE_W - 1);

    slv_state_e st, nxt;
    logic sda_s, rise, fall, start, stop;
    logic [BYTE_W-1:0] sh, areg, tx_buf;
    logic [CNT_W-1:0] cnt;
    logic addressed, tx_pend, mack;
    logic in_rx, in_ack, rx_done, tx_done, hit, load, sh_en;

    i2c10_line_mon #(.SYNC_STAGES(SYNC_STAGES)) u_mon (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .sda_now(sda_s), .scl_rise(rise), .scl_fall(fall),
        .bus_start(start), .bus_stop(stop)
    );

    assign in_rx  = (st == ST_HDR_W) || (st == ST_RX_LO) || (st == ST_HDR_R);
    assign in_ack = (st == ST_ACK_W) || (st == ST_ACK_LO) || (st == ST_ACK_R);
    assign rx_done = in_rx && fall && (cnt == LAST_RX);
    assign tx_done = (st == ST_TX_BIT) && fall && (cnt == LAST_TX);
    assign load   = (st == ST_HOLD_TX) && (nxt == ST_TX_BIT);
    assign sh_en  = (in_rx && rise) || ((st == ST_TX_BIT) && fall);

    always_comb begin
        unique case (st)
            ST_HDR_W: hit = hdr_hit(sh, areg, 1'b0);
            ST_RX_LO: hit = (sh == areg);
            ST_HDR_R: hit = hdr_hit(sh, areg, 1'b1);
            default:  hit = 1'b0;
        endcase
    end

    i2c10_bit_engine #(.W(BYTE_W), .CNT_W(CNT_W)) u_bits (
        .clk(clk), .rst_n(rst_n),
        .clr(start || stop || (in_ack && fall)),
        .load(load), .load_val(tx_buf),
        .shift_en(sh_en), .shift_in((st == ST_TX_BIT) ? 1'b0 : sda_s),
        .data(sh), .cnt(cnt)
    );

    // next-state logic
    always_comb begin
        nxt = st;
        if (stop) begin
            nxt = ST_IDLE;
        end else if (start) begin
            nxt = addressed ? ST_HDR_R : ST_HDR_W;
        end else begin
            unique case (st)
                ST_IDLE, ST_WAIT_SR, ST_NACK_WAIT: nxt = st;
                ST_HDR_W:   if (rx_done) nxt = hit ? ST_ACK_W  : ST_IDLE;
                ST_ACK_W:   if (fall)    nxt = ST_HOLD_LO;
                ST_HOLD_LO: if (addr_wr) nxt = ST_RX_LO;
                ST_RX_LO:   if (rx_done) nxt = hit ? ST_ACK_LO : ST_IDLE;
                ST_ACK_LO:  if (fall)    nxt = ST_HOLD_HI;
                ST_HOLD_HI: if (addr_wr) nxt = ST_WAIT_SR;
                ST_HDR_R:   if (rx_done) nxt = hit ? ST_ACK_R  : ST_IDLE;
                ST_ACK_R:   if (fall)    nxt = ST_HOLD_TX;
                ST_HOLD_TX: if (clk_rel && tx_pend) nxt = ST_TX_BIT;
                ST_TX_BIT:  if (tx_done) nxt = ST_TX_ACK;
                ST_TX_ACK:  if (fall)    nxt = mack ? ST_HOLD_TX : ST_NACK_WAIT;
                default:    nxt = ST_IDLE;
            endcase
        end
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= nxt;
    end

    // host-visible registers and flags
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            areg      <= ADDR_RESET;
            tx_buf    <= '0;
            tx_pend   <= 1'b0;
            addressed <= 1'b0;
            mack      <= 1'b0;
            upd_addr  <= 1'b0;
            buf_full  <= 1'b0;
            irq_flag  <= 1'b0;
            clk_rel   <= 1'b1;
        end else begin
            if (addr_wr) areg <= addr_wdata;
            if (tx_wr) tx_buf <= tx_wdata;

            if (tx_wr)              tx_pend <= 1'b1;
            else if (load || stop)  tx_pend <= 1'b0;

            if (st == ST_HOLD_HI && addr_wr && !stop) addressed <= 1'b1;
            else if (nxt == ST_IDLE)                  addressed <= 1'b0;

            if (st == ST_TX_ACK && rise) mack <= ~sda_s;

            if ((st == ST_ACK_W || st == ST_ACK_LO) && fall) upd_addr <= 1'b1;
            else if (addr_wr)                                upd_addr <= 1'b0;

            if ((rx_done && hit) || tx_wr)  buf_full <= 1'b1;
            else if (buf_rd || tx_done)     buf_full <= 1'b0;

            if ((in_ack || st == ST_TX_ACK) && fall) irq_flag <= 1'b1;
            else if (flag_clr)                      irq_flag <= 1'b0;

            if (rel_set)                                   clk_rel <= 1'b1;
            else if ((st == ST_ACK_R || (st == ST_TX_ACK && mack)) && fall)
                                                           clk_rel <= 1'b0;
        end
    end

    // line drivers
    always_comb begin
        scl_oe = 1'b0;
        sda_oe = 1'b0;
        unique case (st)
            ST_ACK_W, ST_ACK_LO, ST_ACK_R: sda_oe = 1'b1;
            ST_HOLD_LO, ST_HOLD_HI:        scl_oe = 1'b1;
            ST_HOLD_TX: begin
                scl_oe = 1'b1;
                sda_oe = tx_pend & ~tx_buf[BYTE_W-1];
            end
            ST_TX_BIT:                     sda_oe = ~sh[BYTE_W-1];
            default: ;
        endcase
    end
endmodule

// File: rtl/i2c10_slave_tx_chk.sv
module i2c10_slave_tx_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_i,
    input logic sda_oe,
    input logic scl_oe,
    input logic addr_wr,
    input logic tx_wr,
    input logic buf_rd,
    input logic rel_set,
    input logic flag_clr,
    input logic buf_full,
    input logic irq_flag,
    input logic upd_addr,
    input logic clk_rel
);
    AST_SDA_MOVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !scl_i); // R11

    AST_UPD_STRETCHES: assert property (@(posedge clk) disable iff (!rst_n)
        upd_addr |-> scl_oe); // R3

    AST_UPD_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        upd_addr && addr_wr |=> !upd_addr); // R3

    AST_BUF_READ_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
        buf_rd && !tx_wr && scl_oe |=> !buf_full); // R5

    AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        irq_flag && !flag_clr |=> irq_flag); // R6

    AST_HOLD_UNTIL_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        scl_oe && !clk_rel && !rel_set && !addr_wr |=> scl_oe); // R7
endmodule

bind i2c10_slave_tx i2c10_slave_tx_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_oe(sda_oe), .scl_oe(scl_oe),
    .addr_wr(addr_wr), .tx_wr(tx_wr), .buf_rd(buf_rd), .rel_set(rel_set),
    .flag_clr(flag_clr), .buf_full(buf_full), .irq_flag(irq_flag),
    .upd_addr(upd_addr), .clk_rel(clk_rel)
);

// File: tb/test_i2c10_slave_tx.sv
module test_i2c10_slave_tx;
    localparam int Q = 6;
    localparam int TRANS = 30;

    logic clk = 1'b0, rst_n = 1'b0;
    logic m_scl = 1'b1, m_sda = 1'b1;
    logic scl_oe, sda_oe, buf_full, irq_flag, upd_addr, clk_rel;
    logic addr_wr = 0, tx_wr = 0, buf_rd = 0, rel_set = 0, flag_clr = 0;
    logic [7:0] addr_wdata = 0, tx_wdata = 0;
    wire scl_line = m_scl & ~scl_oe;
    wire sda_line = m_sda & ~sda_oe;
    int checks = 0, errors = 0;
    logic [7:0] areg = 8'hF2;

    always #2 clk = ~clk;

    i2c10_slave_tx i_i2c10_slave_tx (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_line), .sda_i(sda_line),
        .scl_oe(scl_oe), .sda_oe(sda_oe), .addr_wr(addr_wr), .addr_wdata(addr_wdata),
        .tx_wr(tx_wr), .tx_wdata(tx_wdata), .buf_rd(buf_rd), .rel_set(rel_set),
        .flag_clr(flag_clr), .buf_full(buf_full), .irq_flag(irq_flag),
        .upd_addr(upd_addr), .clk_rel(clk_rel)
    );

    function automatic bit exp_hdr(input logic [7:0] b, input logic [7:0] r, input bit rw);
        return b[7:3] == 5'b11110 && b[2:1] == r[2:1] && b[0] == rw;
    endfunction

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic clock_bit(input bit b, output bit seen);
        idle(Q); m_sda = b; idle(Q); m_scl = 1'b1;
        while (!scl_line) @(negedge clk);
        idle(Q); seen = sda_line; m_scl = 1'b0;
    endtask

    task automatic i2c_start;
        m_sda = 1; m_scl = 1; idle(Q); m_sda = 0; idle(Q); m_scl = 0;
    endtask

    task automatic i2c_rstart;
        idle(Q); m_sda = 1; idle(Q); m_scl = 1;
        while (!scl_line) @(negedge clk);
        idle(Q); m_sda = 0; idle(Q); m_scl = 0;
    endtask

    task automatic i2c_stop;
        idle(Q); m_sda = 0; idle(Q); m_scl = 1;
        while (!scl_line) @(negedge clk);
        idle(Q); m_sda = 1; idle(Q);
    endtask

    task automatic send_byte(input logic [7:0] b, output bit ack);
        bit s;
        for (int i = 7; i >= 0; i--) clock_bit(b[i], s);
        clock_bit(1'b1, s);
        ack = !s;
    endtask

    task automatic recv_byte(input bit mack, output logic [7:0] d);
        bit s;
        for (int i = 7; i >= 0; i--) begin clock_bit(1'b1, s); d[i] = s; end
        clock_bit(!mack, s);
    endtask

    task automatic host_addr(input logic [7:0] v);
        @(negedge clk); addr_wr = 1; addr_wdata = v; @(negedge clk); addr_wr = 0;
        areg = v;
    endtask
    task automatic host_tx(input logic [7:0] v);
        @(negedge clk); tx_wr = 1; tx_wdata = v; @(negedge clk); tx_wr = 0;
    endtask
    task automatic host_ack_flags;
        @(negedge clk); buf_rd = 1; flag_clr = 1; @(negedge clk); buf_rd = 0; flag_clr = 0;
    endtask
    task automatic host_release;
        @(negedge clk); rel_set = 1; @(negedge clk); rel_set = 0;
    endtask

    // one full ten-bit read; corrupt selects a wrong byte for stage 1, 2 or 3
    task automatic transaction(input int corrupt, input logic [7:0] lo,
                               input logic [1:0] hi_next, input logic [7:0] d0,
                               input logic [7:0] d1, input bit two);
        logic [7:0] b, hi, got;
        bit ack, expv;
        hi = areg;
        b = {5'b11110, areg[2:1], 1'b0};
        if (corrupt == 1) b = b ^ (8'h1 << $urandom_range(7, 0));
        expv = exp_hdr(b, areg, 1'b0);
        i2c_start; send_byte(b, ack);
        chk(ack == expv, "R2 write header ack", ack, expv);
        if (!ack) begin i2c_stop; return; end
        idle(3 * Q);
        chk(scl_oe && upd_addr, "R3 hold after header", {scl_oe, upd_addr}, 2'b11);
        chk(buf_full && irq_flag, "R5 R6 flags after header", {buf_full, irq_flag}, 2'b11);
        host_ack_flags;
        chk(!buf_full, "R5 read clears buffer full", buf_full, 0);
        host_addr(lo);
        chk(!upd_addr && !scl_oe, "R3 write releases", {upd_addr, scl_oe}, 0);
        b = lo;
        if (corrupt == 2) b = lo ^ 8'(1 << $urandom_range(7, 0));
        expv = (b == areg);
        send_byte(b, ack);
        chk(ack == expv, "R4 low byte ack", ack, expv);
        if (!ack) begin i2c_stop; host_addr(hi); return; end
        idle(3 * Q);
        chk(scl_oe && upd_addr, "R3 hold after low byte", {scl_oe, upd_addr}, 2'b11);
        host_ack_flags;
        host_addr({5'b11110, hi_next, 1'b0});
        i2c_rstart;
        b = {5'b11110, areg[2:1], 1'b1};
        if (corrupt == 3) b[2:1] = ~b[2:1];
        expv = exp_hdr(b, areg, 1'b1);
        send_byte(b, ack);
        chk(ack == expv, "R7 read header ack", ack, expv);
        if (!ack) begin i2c_stop; return; end
        idle(3 * Q);
        chk(!clk_rel && scl_oe, "R7 release cleared and held", {clk_rel, scl_oe}, 2'b01);
        host_ack_flags;
        host_tx(d0);
        chk(buf_full, "R8 tx write sets buffer full", buf_full, 1);
        idle(4 * Q);
        chk(scl_oe, "R7 held until release bit", scl_oe, 1);
        host_release;
        recv_byte(two, got);
        chk(got == d0, "R8 first data byte MSB first", got, d0);
        chk(!buf_full, "R8 buffer full cleared after send", buf_full, 0);
        idle(3 * Q);
        chk(irq_flag, "R6 irq after data byte", irq_flag, 1);
        if (two) begin
            chk(!clk_rel && scl_oe, "R9 ack restretches", {clk_rel, scl_oe}, 2'b01);
            host_ack_flags; host_tx(d1); host_release;
            recv_byte(1'b0, got);
            chk(got == d1, "R8 second data byte", got, d1);
            idle(3 * Q);
        end
        chk(!scl_oe && !sda_oe, "R9 nack releases lines", {scl_oe, sda_oe}, 0);
        host_ack_flags;
        i2c_stop;
        chk(!scl_oe && !sda_oe, "R10 idle after stop", {scl_oe, sda_oe}, 0);
    endtask

    initial begin
        int unused_seed;
        bit ack;
        unused_seed = $urandom(32'd4242);
        idle(4); rst_n = 1; idle(2);
        chk(!scl_oe && !sda_oe && !buf_full && !irq_flag && !upd_addr && clk_rel,
            "R1 reset state", {scl_oe, sda_oe, buf_full, irq_flag, upd_addr, clk_rel}, 6'b1);
        // directed: mismatched header, then a good header without new start
        i2c_start; send_byte(8'hF4, ack);
        chk(!ack, "R2 wrong header not acked", ack, 0);
        send_byte(8'hF2, ack);
        chk(!ack, "R2 bytes ignored until start", ack, 0);
        i2c_stop;
        // directed: full transaction with master ack then nack
        transaction(0, 8'h5A, 2'b01, 8'hA5, 8'h3C, 1'b1);
        // directed: read header after stop without address exchange
        i2c_start; send_byte({5'b11110, areg[2:1], 1'b1}, ack);
        chk(!ack, "R10 stop forgets addressing", ack, 0);
        i2c_stop;
        for (int t = 0; t < TRANS; t++) begin
            int c;
            c = ($urandom_range(9, 0) < 6) ? 0 : int'($urandom_range(3, 1));
            transaction(c, 8'($urandom), 2'($urandom), 8'($urandom), 8'($urandom),
                        1'($urandom));
        end
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule